// File: doc/BRIEF.md
# Register-Pair Floating-Point Operand File

This block is the integer register file of a small 32-bit core in which floating-point values are held in the general-purpose registers rather than in a separate bank. It has two combinational read ports and one clocked write port. A two-bit format field on each port selects one of three operand widths. A single operand uses one register. A double operand uses an aligned pair of registers. A quad operand uses an aligned group of four.

A read port gathers a wide operand from consecutive registers, with the lowest-numbered register in the least significant lane. The write port spreads a wide result across consecutive registers in the same way. Each port flags a misaligned start register, or an undefined format code, as an illegal operand. A flagged write changes nothing. Register zero always reads as zero. A write of any width that starts at register zero is discarded as a whole, so the registers above it keep their values.

Top module: `fpx_regfile`

## Requirements
- R1: With format 2'b00 (single), a read port returns register `idx` in bits 31:0 and zeros in bits 127:32, for any index.
- R2: With format 2'b01 (double) and an even index, bits 31:0 hold register `idx`, bits 63:32 hold register `idx+1`, and bits 127:64 are zero.
- R3: With format 2'b10 (quad) and an index that is a multiple of four, lane k (bits 32k+31:32k) holds register `idx+k` for k = 0..3.
- R4: Register 0 reads as zero in every format, so a double read at index 0 returns zero in bits 31:0 and register 1 in bits 63:32.
- R5: A read port raises its illegal flag and outputs all-zero data when the format is 2'b11, when a double index is odd, or when a quad index is not a multiple of four. Each port is judged on its own inputs.
- R6: A legal single write with write enable high updates register `idx` with bits 31:0 of the write data at the rising clock edge.
- R7: A legal double or quad write stores lane k of the write data into register `idx+k` at the same edge.
- R8: The write illegal flag follows the rule of R5 for the write inputs. When it is high, no register changes.
- R9: A write of any format that starts at index 0 is discarded in full, and registers 1 to 3 keep their values.
- R10: A read in the same cycle as a write to the same registers returns the values held before that write.
- R11: Reset clears every register to zero.
- R12: With write enable low, no register changes, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ra_idx | input | 5 | Read port A start register |
| ra_fmt | input | 2 | Read port A format (00 single, 01 double, 10 quad) |
| ra_data | output | 128 | Read port A operand |
| ra_bad | output | 1 | Read port A illegal-operand flag |
| rb_idx | input | 5 | Read port B start register |
| rb_fmt | input | 2 | Read port B format |
| rb_data | output | 128 | Read port B operand |
| rb_bad | output | 1 | Read port B illegal-operand flag |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write start register |
| wr_fmt | input | 2 | Write format |
| wr_data | input | 128 | Write operand, lane k for register idx+k |
| wr_bad | output | 1 | Write illegal-operand flag |

## Verification
The assertions check the following on every cycle:
- a flagged read returns zero data;
- the upper lanes stay zero for single reads;
- a flagged write, a write at register zero, or an idle write port leaves the whole register array untouched;
- a legal single write lands in its register.

Lane ordering of wide operands, the exact alignment rule for each format, and the old-value behaviour of same-cycle reads can only be shown by the bench. The bench keeps its own register model. After every write it sweeps all index and format combinations on both ports, through a write sequence that includes misaligned, zero-index and disabled writes, and after a second reset.

// File: rtl/fpx_regfile.sv
module fpx_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG),
  localparam int DW = 4 * XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] ra_idx,
  input  logic [1:0]    ra_fmt,
  output logic [DW-1:0] ra_data,
  output logic          ra_bad,
  input  logic [IW-1:0] rb_idx,
  input  logic [1:0]    rb_fmt,
  output logic [DW-1:0] rb_data,
  output logic          rb_bad,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_fmt,
  input  logic [DW-1:0] wr_data,
  output logic          wr_bad
);

  logic [NREG-1:0][XLEN-1:0] regs;

  function automatic logic [2:0] lanes_of(input logic [1:0] fmt);
    case (fmt)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic misaligned(input logic [IW-1:0] idx, input logic [1:0] fmt);
    case (fmt)
      2'b00:   return 1'b0;
      2'b01:   return idx[0];
      2'b10:   return |idx[1:0];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [DW-1:0] gather(input logic [NREG-1:0][XLEN-1:0] rf,
                                           input logic [IW-1:0] idx, input logic [1:0] fmt);
    logic [DW-1:0] d;
    logic [IW-1:0] r;
    d = '0;
    for (int k = 0; k < 4; k++) begin
      r = idx + IW'(k);
      if (3'(k) < lanes_of(fmt) && r != '0)
        d[k*XLEN +: XLEN] = rf[r];
    end
    return d;
  endfunction

  assign ra_bad  = misaligned(ra_idx, ra_fmt);
  assign rb_bad  = misaligned(rb_idx, rb_fmt);
  assign wr_bad  = misaligned(wr_idx, wr_fmt);
  assign ra_data = ra_bad ? '0 : gather(regs, ra_idx, ra_fmt);
  assign rb_data = rb_bad ? '0 : gather(regs, rb_idx, rb_fmt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en && !wr_bad && wr_idx != '0) begin
      for (int k = 0; k < 4; k++)
        if (3'(k) < lanes_of(wr_fmt))
          regs[wr_idx + IW'(k)] <= wr_data[k*XLEN +: XLEN];
    end
  end

  assert_bad_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_bad |-> ra_data == '0) and (rb_bad |-> rb_data == '0));

  assert_single_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_bad && ra_fmt == 2'b00) |-> ra_data[DW-1:XLEN] == '0);

  assert_bad_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bad) |=> $stable(regs));

  assert_zero_target_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0) |=> $stable(regs));

  assert_idle_write_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

  assert_single_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fmt == 2'b00 && wr_idx != '0) |=> regs[$past(wr_idx)] == $past(wr_data[XLEN-1:0]));

endmodule

// File: tb/fpx_regfile_bench.sv
module fpx_regfile_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [1:0] ra_fmt = '0, rb_fmt = '0, wr_fmt = '0;
  logic [127:0] ra_data, rb_data, wr_data = '0;
  logic ra_bad, rb_bad, wr_bad, wr_en = 1'b0;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] mdl [32];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  fpx_regfile u_fpx_regfile (.*);

  function automatic int nlanes(input logic [1:0] f);
    return f == 2'b00 ? 1 : f == 2'b01 ? 2 : f == 2'b10 ? 4 : 0;
  endfunction

  function automatic logic ebad(input logic [4:0] i, input logic [1:0] f);
    int n = nlanes(f);
    return n == 0 || (int'(i) % n) != 0;
  endfunction

  function automatic logic [128:0] erd(input logic [4:0] i, input logic [1:0] f);
    logic [127:0] d = '0;
    if (ebad(i, f)) return {1'b1, 128'd0};
    for (int k = 0; k < nlanes(f); k++)
      if (int'(i) + k != 0) d[k*32 +: 32] = mdl[int'(i) + k];
    return {1'b0, d};
  endfunction

  function automatic string tagof(input logic [4:0] i, input logic [1:0] f);
    if (ebad(i, f)) return "R5";
    if (i == 0) return "R4";
    return f == 2'b00 ? "R1" : f == 2'b01 ? "R2" : "R3";
  endfunction

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic chk(input string tag, input string ctx, input logic [128:0] act, input logic [128:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  task automatic sweep(input string ctx);
    for (int f = 0; f < 4; f++)
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        ra_idx = 5'(i); ra_fmt = 2'(f);
        rb_idx = 5'(31 - i); rb_fmt = 2'(f);
        #1;
        chk(tagof(ra_idx, ra_fmt), {ctx, " portA"}, {ra_bad, ra_data}, erd(ra_idx, ra_fmt));
        chk(tagof(rb_idx, rb_fmt), {ctx, " portB"}, {rb_bad, rb_data}, erd(rb_idx, rb_fmt));
      end
  endtask

  task automatic do_wr(input logic en, input logic [4:0] i, input logic [1:0] f, input string tag);
    logic [127:0] d = {nxt(), nxt(), nxt(), nxt()};
    @(negedge clk);
    wr_en = en; wr_idx = i; wr_fmt = f; wr_data = d;
    ra_idx = i; ra_fmt = f;
    #1;
    chk("R8", "write flag", {128'd0, wr_bad}, {128'd0, ebad(i, f)});
    chk("R10", "same-cycle read", {ra_bad, ra_data}, erd(i, f));
    @(posedge clk);
    if (en && !ebad(i, f) && i != 0)
      for (int k = 0; k < nlanes(f); k++) mdl[int'(i) + k] = d[k*32 +: 32];
    @(negedge clk);
    wr_en = 1'b0;
    sweep(tag);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R11 after reset");
    for (int r = 1; r < 32; r++) do_wr(1'b1, 5'(r), 2'b00, "R6 single fill");
    do_wr(1'b1, 5'd14, 2'b01, "R7 double");
    do_wr(1'b1, 5'd8, 2'b10, "R7 quad");
    do_wr(1'b1, 5'd28, 2'b10, "R7 quad top");
    do_wr(1'b1, 5'd0, 2'b01, "R9 double at x0");
    do_wr(1'b1, 5'd0, 2'b10, "R9 quad at x0");
    do_wr(1'b1, 5'd0, 2'b00, "R9 single at x0");
    do_wr(1'b1, 5'd7, 2'b01, "R8 odd double");
    do_wr(1'b1, 5'd6, 2'b10, "R8 misaligned quad");
    do_wr(1'b1, 5'd4, 2'b11, "R8 format 11");
    do_wr(1'b0, 5'd4, 2'b10, "R12 disabled");
    for (int n = 0; n < 32; n++) do_wr(1'b1, 5'((n * 7) % 32), 2'(n % 4), "R7 mixed");
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    sweep("R11 second reset");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule